// File: doc/BRIEF.md
# Serial Configuration Register Interface

This block is the configuration port of a data converter. A host drives three lines: an active-low enable, a serial clock and a serial data line. Over them it writes 16-bit words into a small register file addressed by 8 bits. All three lines are oversampled by a faster system clock through a two-stage synchronizer. Edges of the serial clock and of the enable line are found in the system-clock domain.

The register file sets the converter's low-speed mode, its power states, its reference source, its output interface and its data format. Three of these selections can also come from external pins, which reach the block as already-decoded levels. A register field of `00` hands the choice to the pin, and any other value overrides it. A control register provides a software reset that clears itself and a readback mode. While readback is on, writes are locked out and the addressed register is shifted out on a readout line.

Top module: `cfg_serial_regs`

## Requirements
- R1: Bits are shifted in only while `ser_en_n` is low. Each bit is taken from `ser_din` at a falling edge of `ser_clk`. Clock edges while enable is high have no effect.
- R2: A word is 16 bits, sent MSB first: an 8-bit address followed by 8 data bits. The addressed register is updated after the 16th falling edge of the word.
- R3: Several words may follow one another in one enable-low window. If enable rises before a word is complete, the bits already taken in are discarded and the next window starts a fresh word.
- R4: Writing a word to address 0x00 with data bit 7 set returns every register to its default of 0x00. Bit 7 is never stored, so a later write takes effect normally.
- R5: Bit 0 of address 0x00 turns readback mode on. While it is set, only that bit can be written: writes to other addresses are dropped, and a software reset is dropped as well.
- R6: In readback mode, the addressed register's 8 bits are driven on `ser_dout`, MSB first, during the data half of the word. Each bit is valid before the falling edge on which the host captures it. Outside readback mode `ser_dout` is low.
- R7: The reference field (0x3F bits 6:5) works as follows. 00 follows `pin_ref_ext`, 01 selects internal and 10 or 11 select external (bit 6). The interface field (0x41 bits 7:6) works as follows. 00 follows `pin_if_cmos`, 10 selects the double-rate differential interface and 11 selects parallel CMOS (bit 6). The format field (0x50 bits 2:1) works as follows. 00 follows `pin_fmt_offb`, 01 selects two's complement and 10 or 11 select offset binary (bit 2).
- R8: A synchronous high level on `rst` returns every register to 0x00.
- R9: The register map is as follows. 0x20 bit 2 is low-speed mode. 0x3F bit 2 is global power-down, bit 1 is standby and bit 0 is output-buffer power-down. Bits outside the defined fields read 0 and cannot be set.
- R10: Addresses outside {0x00, 0x20, 0x3F, 0x41, 0x50} read back 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset, also the hardware register reset |
| ser_en_n | input | 1 | Serial enable, active low |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Readback data in readback mode, otherwise low |
| pin_ref_ext | input | 1 | Decoded pin level: 1 selects external reference |
| pin_if_cmos | input | 1 | Decoded pin level: 1 selects parallel CMOS interface |
| pin_fmt_offb | input | 1 | Decoded pin level: 1 selects offset binary format |
| cfg_ref_ext | output | 1 | Resolved reference selection |
| cfg_if_cmos | output | 1 | Resolved interface selection |
| cfg_fmt_offb | output | 1 | Resolved data format selection |
| cfg_low_speed | output | 1 | Low-speed mode enable |
| cfg_pdn_global | output | 1 | Global power-down |
| cfg_standby | output | 1 | Converter standby |
| cfg_pdn_obuf | output | 1 | Output buffer power-down |

## Verification
The hardest state to reach from the ports is a shift counter left part-way through a word, followed by a window that must realign. The stimulus creates it by sending one full word, then ten bits of a second word that would visibly change the interface output, and then raising enable. The next window's complete word must then be decoded correctly. The readback lock is reached in a similar way. The host sets the lock bit, then sends both an ordinary write and a software-reset word combined with the lock bit. It then reads a register over the readout line while still locked, so that the read proves the earlier contents survived.

// File: rtl/cfg_serial_pkg.sv
`timescale 1ns/1ps
package cfg_serial_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam int NREG   = 5;

  // address and writable-bit mask of each implemented register
  localparam logic [ADDR_W-1:0] REG_ADDR [NREG] = '{8'h00, 8'h20, 8'h3F, 8'h41, 8'h50};
  localparam logic [DATA_W-1:0] REG_MASK [NREG] = '{8'h01, 8'h04, 8'h67, 8'hC0, 8'h06};

  localparam int IDX_CTL = 0;
  localparam int IDX_SPD = 1;
  localparam int IDX_PWR = 2;
  localparam int IDX_IF  = 3;
  localparam int IDX_FMT = 4;

  localparam int BIT_SOFT_RST = 7;
  localparam int BIT_RDBK     = 0;
endpackage

// File: rtl/cfg_sync.sv
`timescale 1ns/1ps
module cfg_sync #(
  parameter int            W       = 3,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage[i] <= RST_VAL;
    end else begin
      stage[0] <= d;
      for (int i = 1; i < STAGES; i++) stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/cfg_frame_rx.sv
`timescale 1ns/1ps
module cfg_frame_rx import cfg_serial_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              en_n_s,
  input  logic              din_s,
  output logic              en_act,
  output logic              word_vld,
  output logic              addr_vld,
  output logic [WORD_W-1:0] word,
  output logic [CNT_W-1:0]  bit_cnt
);
  logic sclk_d, en_n_d;
  logic sclk_fall, en_rise;

  assign sclk_fall = sclk_d & ~sclk_s;
  assign en_rise   = ~en_n_d & en_n_s;
  assign en_act    = ~en_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b1;
      en_n_d   <= 1'b1;
      bit_cnt  <= '0;
      word     <= '0;
      word_vld <= 1'b0;
      addr_vld <= 1'b0;
    end else begin
      sclk_d   <= sclk_s;
      en_n_d   <= en_n_s;
      word_vld <= 1'b0;
      addr_vld <= 1'b0;
      if (en_rise) begin
        bit_cnt <= '0;                       // realign after a short word
      end else if (sclk_fall && en_act) begin
        word     <= {word[WORD_W-2:0], din_s};
        word_vld <= (bit_cnt == CNT_W'(WORD_W-1));
        addr_vld <= (bit_cnt == CNT_W'(ADDR_W-1));
        if (bit_cnt == CNT_W'(WORD_W-1)) bit_cnt <= '0;
        else                             bit_cnt <= bit_cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
`timescale 1ns/1ps
module cfg_reg_bank import cfg_serial_pkg::*; (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_vld,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic [NREG*DATA_W-1:0] regs_flat
);
  logic [DATA_W-1:0] bank [NREG];
  logic [NREG-1:0]   hit;
  logic              lock, soft_rst;

  assign lock     = bank[IDX_CTL][BIT_RDBK];
  assign soft_rst = wr_vld && !lock && (wr_addr == REG_ADDR[IDX_CTL]) && wr_data[BIT_SOFT_RST];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign hit[g] = wr_vld && (wr_addr == REG_ADDR[g]) && (!lock || (g == IDX_CTL));
    assign regs_flat[g*DATA_W +: DATA_W] = bank[g];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst || soft_rst)  bank[i] <= '0;
      else if (hit[i])      bank[i] <= wr_data & REG_MASK[i];
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (rd_addr == REG_ADDR[i]) rd_data = rd_data | bank[i];
  end
endmodule

// File: rtl/cfg_serial_regs.sv
`timescale 1ns/1ps
module cfg_serial_regs import cfg_serial_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ser_en_n,
  input  logic ser_clk,
  input  logic ser_din,
  output logic ser_dout,
  input  logic pin_ref_ext,
  input  logic pin_if_cmos,
  input  logic pin_fmt_offb,
  output logic cfg_ref_ext,
  output logic cfg_if_cmos,
  output logic cfg_fmt_offb,
  output logic cfg_low_speed,
  output logic cfg_pdn_global,
  output logic cfg_standby,
  output logic cfg_pdn_obuf
);
  logic [2:0]             sync_q;
  logic                   en_act, word_vld, addr_vld;
  logic [WORD_W-1:0]      word;
  logic [CNT_W-1:0]       bit_cnt, dpos;
  logic [ADDR_W-1:0]      rd_addr_q;
  logic [DATA_W-1:0]      rd_data;
  logic [NREG*DATA_W-1:0] regs_flat;
  logic                   lock, dbit;
  logic [1:0]             ref_f, if_f, fmt_f;
  logic                   unused_bits;

  cfg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk(clk), .rst(rst), .d({ser_en_n, ser_clk, ser_din}), .q(sync_q)
  );

  cfg_frame_rx u_rx (
    .clk(clk), .rst(rst), .sclk_s(sync_q[1]), .en_n_s(sync_q[2]), .din_s(sync_q[0]),
    .en_act(en_act), .word_vld(word_vld), .addr_vld(addr_vld), .word(word), .bit_cnt(bit_cnt)
  );

  cfg_reg_bank u_bank (
    .clk(clk), .rst(rst), .wr_vld(word_vld),
    .wr_addr(word[WORD_W-1:DATA_W]), .wr_data(word[DATA_W-1:0]),
    .rd_addr(rd_addr_q), .rd_data(rd_data), .regs_flat(regs_flat)
  );

  assign lock  = regs_flat[IDX_CTL*DATA_W + BIT_RDBK];
  assign ref_f = regs_flat[IDX_PWR*DATA_W + 5 +: 2];
  assign if_f  = regs_flat[IDX_IF*DATA_W  + 6 +: 2];
  assign fmt_f = regs_flat[IDX_FMT*DATA_W + 1 +: 2];
  assign unused_bits = ^regs_flat;

  // data-phase bit position: counter value ADDR_W maps to data MSB
  assign dpos = CNT_W'(WORD_W-1) - bit_cnt;
  always_comb begin
    dbit = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (dpos == CNT_W'(i)) dbit = rd_data[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_addr_q      <= '0;
      ser_dout       <= 1'b0;
      cfg_ref_ext    <= 1'b0;
      cfg_if_cmos    <= 1'b0;
      cfg_fmt_offb   <= 1'b0;
      cfg_low_speed  <= 1'b0;
      cfg_pdn_global <= 1'b0;
      cfg_standby    <= 1'b0;
      cfg_pdn_obuf   <= 1'b0;
    end else begin
      if (addr_vld) rd_addr_q <= word[ADDR_W-1:0];
      ser_dout       <= lock && en_act && (bit_cnt >= CNT_W'(ADDR_W)) && dbit;
      cfg_ref_ext    <= (ref_f == 2'b00) ? pin_ref_ext  : ref_f[1];
      cfg_if_cmos    <= (if_f  == 2'b00) ? pin_if_cmos  : if_f[0];
      cfg_fmt_offb   <= (fmt_f == 2'b00) ? pin_fmt_offb : fmt_f[1];
      cfg_low_speed  <= regs_flat[IDX_SPD*DATA_W + 2];
      cfg_pdn_global <= regs_flat[IDX_PWR*DATA_W + 2];
      cfg_standby    <= regs_flat[IDX_PWR*DATA_W + 1];
      cfg_pdn_obuf   <= regs_flat[IDX_PWR*DATA_W + 0];
    end
  end
endmodule

// File: rtl/cfg_serial_regs_chk.sv
`timescale 1ns/1ps
module cfg_serial_regs_chk import cfg_serial_pkg::*; (
  input logic                   clk,
  input logic                   rst,
  input logic                   en_act,
  input logic                   word_vld,
  input logic [ADDR_W-1:0]      wr_addr,
  input logic                   wr_top,
  input logic                   lock,
  input logic [NREG*DATA_W-1:0] regs_flat,
  input logic                   pin_ref_ext,
  input logic                   cfg_ref_ext,
  input logic                   ser_dout
);
  logic [1:0] ref_f;
  assign ref_f = regs_flat[IDX_PWR*DATA_W + 5 +: 2];

  p_idle_no_write_r1: assert property (@(posedge clk) disable iff (rst)
    !en_act |=> !word_vld);

  p_soft_reset_clears_r4: assert property (@(posedge clk) disable iff (rst)
    (word_vld && !lock && wr_addr == REG_ADDR[IDX_CTL] && wr_top) |=> (regs_flat == '0));

  p_lock_holds_r5: assert property (@(posedge clk) disable iff (rst)
    lock |=> $stable(regs_flat[NREG*DATA_W-1:DATA_W]));

  p_quiet_dout_r6: assert property (@(posedge clk) disable iff (rst)
    !lock |=> !ser_dout);

  p_field_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (ref_f != 2'b00) |=> (cfg_ref_ext == $past(ref_f[1])));

  p_pin_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (ref_f == 2'b00) |=> (cfg_ref_ext == $past(pin_ref_ext)));
endmodule

bind cfg_serial_regs cfg_serial_regs_chk u_chk (
  .clk(clk), .rst(rst), .en_act(en_act), .word_vld(word_vld),
  .wr_addr(word[WORD_W-1:DATA_W]), .wr_top(word[DATA_W-1]),
  .lock(lock), .regs_flat(regs_flat), .pin_ref_ext(pin_ref_ext),
  .cfg_ref_ext(cfg_ref_ext), .ser_dout(ser_dout)
);

// File: tb/cfg_serial_regs_tb.sv
`timescale 1ns/1ps
module cfg_serial_regs_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_en_n = 1'b1, ser_clk = 1'b1, ser_din = 1'b0;
  logic ser_dout;
  logic pin_ref_ext = 1'b1, pin_if_cmos = 1'b0, pin_fmt_offb = 1'b1;
  logic cfg_ref_ext, cfg_if_cmos, cfg_fmt_offb, cfg_low_speed;
  logic cfg_pdn_global, cfg_standby, cfg_pdn_obuf;
  int   checks = 0, failures = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  cfg_serial_regs u_dut (
    .clk(clk), .rst(rst), .ser_en_n(ser_en_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_dout(ser_dout), .pin_ref_ext(pin_ref_ext), .pin_if_cmos(pin_if_cmos),
    .pin_fmt_offb(pin_fmt_offb), .cfg_ref_ext(cfg_ref_ext), .cfg_if_cmos(cfg_if_cmos),
    .cfg_fmt_offb(cfg_fmt_offb), .cfg_low_speed(cfg_low_speed),
    .cfg_pdn_global(cfg_pdn_global), .cfg_standby(cfg_standby), .cfg_pdn_obuf(cfg_pdn_obuf)
  );

  // {address, write data, expected readback}
  localparam logic [23:0] VEC [6] = '{
    {8'h20, 8'hFF, 8'h04}, {8'h3F, 8'hFF, 8'h67}, {8'h41, 8'hC0, 8'hC0},
    {8'h50, 8'h02, 8'h02}, {8'h7E, 8'hFF, 8'h00}, {8'h3F, 8'h25, 8'h25}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] w, input int nbits, output logic [7:0] cap);
    cap = '0;
    for (int i = 15; i > 15 - nbits; i--) begin
      ser_din = w[i];
      wait_clk(4);
      if (i < 8) cap[i] = ser_dout;
      ser_clk = 1'b0;
      wait_clk(4);
      ser_clk = 1'b1;
    end
  endtask

  task automatic win_open();
    ser_en_n = 1'b0; wait_clk(4);
  endtask

  task automatic win_close();
    wait_clk(4); ser_en_n = 1'b1; wait_clk(12);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] cap;
    win_open(); send_bits({a, d}, 16, cap); win_close();
  endtask

  task automatic rd_locked(input logic [7:0] a, output logic [7:0] d);
    win_open(); send_bits({a, 8'h00}, 16, d); win_close();
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    wr(8'h00, 8'h01);
    rd_locked(a, d);
    wr(8'h00, 8'h00);
  endtask

  function automatic logic [7:0] outs();
    return {1'b0, cfg_ref_ext, cfg_if_cmos, cfg_fmt_offb,
            cfg_low_speed, cfg_pdn_global, cfg_standby, cfg_pdn_obuf};
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic [7:0] cap;
    wait_clk(5); rst = 1'b0; wait_clk(5);
    // R8 reset state: fields 00 so pins pass (ref=1, if=0, fmt=1)
    chk("R8 reset outputs", outs(), 8'b0101_0000);

    // R2 R9 R10 vector table: write, read back over the serial line
    for (int k = 0; k < 6; k++) begin
      wr(VEC[k][23:16], VEC[k][15:8]);
      rd(VEC[k][23:16], d);
      chk($sformatf("R2/R9/R10 readback addr %h", VEC[k][23:16]), d, VEC[k][7:0]);
    end
    // R9 R7: 20=04, 3F=25 (ref 01 internal, gpd=1, sb=0, obuf=1), 41=C0 cmos, 50=02 twos
    chk("R9/R7 outputs after table", outs(), 8'b0010_1101);

    wr(8'h3F, 8'h00);
    chk("R7 ref field 00 follows pin", {7'd0, cfg_ref_ext}, 8'd1);

    // R3 two words in one window
    win_open(); send_bits({8'h41, 8'h80}, 16, cap); send_bits({8'h50, 8'h04}, 16, cap); win_close();
    chk("R3 two words if field 10", {7'd0, cfg_if_cmos}, 8'd0);
    chk("R3 two words fmt field 10", {7'd0, cfg_fmt_offb}, 8'd1);

    // R3 partial word discarded, then realignment
    win_open(); send_bits({8'h20, 8'h00}, 16, cap); send_bits({8'h41, 8'hC0}, 10, cap); win_close();
    chk("R3 full word before partial", {7'd0, cfg_low_speed}, 8'd0);
    chk("R3 partial word discarded", {7'd0, cfg_if_cmos}, 8'd0);
    wr(8'h41, 8'hC0);
    chk("R3 realigned after partial", {7'd0, cfg_if_cmos}, 8'd1);

    // R1 clock edges with enable high do nothing
    send_bits({8'h20, 8'h04}, 16, cap); wait_clk(12);
    chk("R1 edges while enable high", {7'd0, cfg_low_speed}, 8'd0);

    // R6 ser_dout low outside readback
    win_open(); send_bits({8'h41, 8'hC0}, 16, cap); win_close();
    chk("R6 dout low when not in readback", cap, 8'h00);

    // R5 lock blocks writes and soft reset
    wr(8'h00, 8'h01);
    wr(8'h20, 8'h04);
    chk("R5 write dropped under lock", {7'd0, cfg_low_speed}, 8'd0);
    wr(8'h00, 8'h81);
    chk("R5 soft reset dropped under lock", {7'd0, cfg_if_cmos}, 8'd1);
    rd_locked(8'h41, d);
    chk("R6 readback under lock", d, 8'hC0);
    wr(8'h00, 8'h00);

    // R4 soft reset then self-clear
    wr(8'h20, 8'h04);
    wr(8'h00, 8'h80);
    chk("R4 soft reset defaults", outs(), 8'b0101_0000);
    wr(8'h20, 8'h04);
    chk("R4 reset bit self-clears", {7'd0, cfg_low_speed}, 8'd1);

    // R8 hardware reset
    wr(8'h41, 8'hC0);
    rst = 1'b1; wait_clk(3); rst = 1'b0; wait_clk(4);
    chk("R8 hardware reset defaults", outs(), 8'b0101_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule